// File: doc/BRIEF.md
# Fixed-Point to Signed Integer Rounder

This block takes a sign bit and an unsigned fixed-point magnitude carrying seven fraction bits, rounds the magnitude to a whole number under one of four rounding directions, applies the sign, and returns a 32-bit two's-complement integer. The magnitude is 64 bits wide with the binary point sitting below bit 7. Its top bit is expected to be zero. It is meant to sit at the tail of a floating-point to integer conversion path, after the operand has been aligned so that its integer part occupies the upper bits.

Three status bits come with each result. Invalid means the rounded value does not fit the signed 32-bit range; the result is then forced to the integer-indefinite pattern 0x80000000. Inexact means some fraction bits were discarded. Rounded-up means the returned magnitude is larger than the exact one. Accumulating these into sticky state, masking and trapping are the caller's job. The block is one register stage: a result and its flags appear on the cycle after a valid input, marked by an output valid strobe.

Top module: `fxp_int_rounder`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge and carries that operation's result. When `in_valid` is low, `out_valid` is low after the edge. Reset clears `out_valid`, `out_int` and all flags.
- R2: Mode encoding on `in_mode`: 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero. In nearest-even mode a fraction above one half (more than 0x40 of 0x80) rounds the magnitude up and a fraction below one half truncates it.
- R3: In nearest-even mode a fraction of exactly one half (fraction field 0x40) rounds to the even neighbour: odd integer parts go up, even integer parts stay.
- R4: Toward-zero mode (3) always truncates the fraction and never asserts rounded-up.
- R5: Toward plus infinity (2) raises the magnitude of a positive value that has a nonzero fraction and truncates a negative one. Toward minus infinity (1) raises the magnitude of a negative value that has a nonzero fraction and truncates a positive one.
- R6: When `in_neg` is 1 the result is the two's-complement negation of the rounded magnitude. A zero magnitude gives 0 with either sign.
- R7: A rounded magnitude of 2^32 or more raises invalid and returns 0x80000000.
- R8: A positive rounded magnitude of 2^31 or more, or a negative one above 2^31, raises invalid with result 0x80000000. A negative rounded magnitude of exactly 2^31 is valid and returns 0x80000000 without invalid.
- R9: Inexact is raised exactly when any of the 7 fraction bits is nonzero and the result is not invalid.
- R10: Rounded-up is raised exactly when the returned magnitude exceeds the exact input magnitude and the result is not invalid. It implies inexact.
- R11: Whenever invalid is raised, inexact and rounded-up are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation strobe |
| in_neg | input | 1 | Sign of the value, 1 for negative |
| in_mag | input | 64 | Unsigned magnitude, 7 fraction bits, bit 63 zero |
| in_mode | input | 2 | Rounding direction (0 near-even, 1 down, 2 up, 3 zero) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 32 | Rounded signed integer or 0x80000000 on invalid |
| out_invalid | output | 1 | Result out of signed 32-bit range |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_rounded_up | output | 1 | Returned magnitude exceeds the exact one |

## Verification
On every cycle the assertions check the one-cycle handshake, that an invalid result always carries the indefinite pattern with both other flags low, that rounded-up never appears without inexact, and that toward-zero inputs and exact inputs never raise rounded-up or inexact respectively. Whether a given fraction rounds in the right direction, whether ties go to the even neighbour, and where exactly the signed range ends for each sign can only be shown by the bench, which compares each result against an independent model over hand-picked boundary values and a spread of random operands.

// File: rtl/fxr_pkg.sv
`timescale 1ns/1ps
package fxr_pkg;

    // Rounding direction selector; encoding is visible on the top port.
    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_FLOOR     = 2'd1,
        RND_CEIL      = 2'd2,
        RND_TRUNC     = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/fxr_incr_sel.sv
`timescale 1ns/1ps
// Picks the constant added below the binary point before truncation.
module fxr_incr_sel
    import fxr_pkg::*;
#(
    parameter int FRAC_W = 7
) (
    input  logic [1:0]        mode,
    input  logic              neg,
    output logic [FRAC_W-1:0] bias,
    output logic              even_tie
);

    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);
    localparam logic [FRAC_W-1:0] FULL = '1;

    always_comb begin
        bias     = '0;
        even_tie = 1'b0;
        case (rnd_mode_e'(mode))
            RND_NEAR_EVEN: begin
                bias     = HALF;
                even_tie = 1'b1;
            end
            RND_FLOOR:  bias = neg ? FULL : '0;
            RND_CEIL:   bias = neg ? '0 : FULL;
            default:    bias = '0;
        endcase
    end

endmodule

// File: rtl/fxr_round_mag.sv
`timescale 1ns/1ps
// Adds the bias, drops the fraction, applies tie-to-even, and reports
// whether any fraction was present and whether the magnitude grew.
module fxr_round_mag #(
    parameter int MAG_W  = 64,
    parameter int FRAC_W = 7,
    parameter int RM_W   = MAG_W + 1 - FRAC_W
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic [FRAC_W-1:0] bias,
    input  logic              even_tie,
    output logic [RM_W-1:0]   rmag,
    output logic              frac_nz,
    output logic              grew
);

    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

    logic [MAG_W:0]    sum;
    logic [FRAC_W-1:0] frac;
    logic              clear_lsb;

    always_comb begin
        frac      = mag[FRAC_W-1:0];
        sum       = {1'b0, mag} + {{(MAG_W + 1 - FRAC_W){1'b0}}, bias};
        clear_lsb = even_tie && (frac == HALF);
        rmag      = sum[MAG_W:FRAC_W] & ~{{(RM_W - 1){1'b0}}, clear_lsb};
        frac_nz   = |frac;
        grew      = {rmag, {FRAC_W{1'b0}}} > {1'b0, mag};
    end

endmodule

// File: rtl/fxr_int_pack.sv
`timescale 1ns/1ps
// Applies the sign and detects values outside the signed integer range.
module fxr_int_pack #(
    parameter int RM_W  = 58,
    parameter int INT_W = 32
) (
    input  logic             neg,
    input  logic [RM_W-1:0]  rmag,
    output logic [INT_W-1:0] z,
    output logic             bad
);

    logic [INT_W-1:0] low;
    logic             high_nz;

    always_comb begin
        low     = rmag[INT_W-1:0];
        high_nz = |rmag[RM_W-1:INT_W];
        z       = neg ? (~low + INT_W'(1)) : low;
        bad     = high_nz || ((z != '0) && (z[INT_W-1] != neg));
    end

endmodule

// File: rtl/fxp_int_rounder.sv
`timescale 1ns/1ps
module fxp_int_rounder
    import fxr_pkg::*;
#(
    parameter int MAG_W  = 64,
    parameter int FRAC_W = 7,
    parameter int INT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_neg,
    input  logic [MAG_W-1:0] in_mag,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_rounded_up
);

    localparam int               RM_W  = MAG_W + 1 - FRAC_W;
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W - 1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] val;
        logic             inv;
        logic             inx;
        logic             up;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [FRAC_W-1:0] bias_w;
    logic              tie_w;
    logic [RM_W-1:0]   rmag_w;
    logic              frac_nz_w;
    logic              grew_w;
    logic [INT_W-1:0]  z_w;
    logic              bad_w;

    fxr_incr_sel #(.FRAC_W(FRAC_W)) u_incr (
        .mode     (in_mode),
        .neg      (in_neg),
        .bias     (bias_w),
        .even_tie (tie_w)
    );

    fxr_round_mag #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .RM_W(RM_W)) u_round (
        .mag      (in_mag),
        .bias     (bias_w),
        .even_tie (tie_w),
        .rmag     (rmag_w),
        .frac_nz  (frac_nz_w),
        .grew     (grew_w)
    );

    fxr_int_pack #(.RM_W(RM_W), .INT_W(INT_W)) u_pack (
        .neg  (in_neg),
        .rmag (rmag_w),
        .z    (z_w),
        .bad  (bad_w)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.inv = bad_w;
            stage_d.val = bad_w ? INDEF : z_w;
            stage_d.inx = frac_nz_w && !bad_w;
            stage_d.up  = grew_w && !bad_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid      = stage_q.vld;
    assign out_int        = stage_q.val;
    assign out_invalid    = stage_q.inv;
    assign out_inexact    = stage_q.inx;
    assign out_rounded_up = stage_q.up;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_TRUNC_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == RND_TRUNC) |=> !out_rounded_up); // R4
    AST_INDEF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_int == INDEF)); // R7
    AST_POS_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_neg) |=> (out_invalid || !out_int[INT_W-1])); // R8
    AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mag[FRAC_W-1:0] == '0) |=> !out_inexact); // R9
    AST_UP_IMPLIES_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rounded_up) |-> out_inexact); // R10
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (!out_inexact && !out_rounded_up)); // R11

endmodule

// File: tb/fxp_int_rounder_test.sv
`timescale 1ns/1ps
module fxp_int_rounder_test;

    localparam logic [1:0] M_NEAR = 2'd0;
    localparam logic [1:0] M_DOWN = 2'd1;
    localparam logic [1:0] M_UP   = 2'd2;
    localparam logic [1:0] M_ZERO = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_neg = 1'b0;
    logic [63:0] in_mag = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_rounded_up;

    always #10 clk = ~clk;

    fxp_int_rounder uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_neg         (in_neg),
        .in_mag         (in_mag),
        .in_mode        (in_mode),
        .out_valid      (out_valid),
        .out_int        (out_int),
        .out_invalid    (out_invalid),
        .out_inexact    (out_inexact),
        .out_rounded_up (out_rounded_up)
    );

    typedef struct packed {
        logic [31:0] val;
        logic        inv;
        logic        inx;
        logic        up;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Independent reference: decide a +1 step from integer part and fraction.
    function automatic exp_t model(logic neg, logic [63:0] mag, logic [1:0] mode);
        logic [63:0] ip;
        logic [6:0]  fr;
        logic        step;
        logic [63:0] rm;
        exp_t        e;
        ip = mag >> 7;
        fr = mag[6:0];
        case (mode)
            M_NEAR:  step = (fr > 7'd64) || (fr == 7'd64 && ip[0]);
            M_DOWN:  step = neg && (fr != 0);
            M_UP:    step = !neg && (fr != 0);
            default: step = 1'b0;
        endcase
        rm    = ip + 64'(step);
        e.inv = neg ? (rm > 64'h8000_0000) : (rm >= 64'h8000_0000);
        if (e.inv) begin
            e.val = 32'h8000_0000;
            e.inx = 1'b0;
            e.up  = 1'b0;
        end else begin
            e.val = neg ? 32'(64'd0 - rm) : rm[31:0];
            e.inx = (fr != 0);
            e.up  = step;
        end
        return e;
    endfunction

    function automatic logic [63:0] fx(logic [63:0] ip, logic [6:0] fr);
        return (ip << 7) | 64'(fr);
    endfunction

    task automatic send(logic neg, logic [63:0] mag, logic [1:0] mode, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_neg   = neg;
        in_mag   = mag;
        in_mode  = mode;
        exp_q.push_back(model(neg, mag, mode));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic direct_check(bit ok, string tag, string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Monitor: pops one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            exp_t  e;
            string t;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1: unexpected out_valid, got %h, expected no result", out_int);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_int !== e.val || out_invalid !== e.inv ||
                    out_inexact !== e.inx || out_rounded_up !== e.up) begin
                    n_bad++;
                    $display("FAIL %s: got int=%h inv=%b inx=%b up=%b, expected int=%h inv=%b inx=%b up=%b",
                             t, out_int, out_invalid, out_inexact, out_rounded_up,
                             e.val, e.inv, e.inx, e.up);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        direct_check(out_valid === 1'b0 && out_int === 32'h0 && out_invalid === 1'b0 &&
                     out_inexact === 1'b0 && out_rounded_up === 1'b0,
                     "R1", $sformatf("reset state got v=%b int=%h, expected 0", out_valid, out_int));
        rst_n = 1'b1;
        idle(2);

        // R2 nearest-even above/below one half
        send(1'b0, fx(5, 7'h41), M_NEAR, "R2 above half");
        send(1'b0, fx(5, 7'h3F), M_NEAR, "R2 below half");
        send(1'b1, fx(9, 7'h7F), M_NEAR, "R2 negative above half");
        // R3 ties
        send(1'b0, fx(5, 7'h40), M_NEAR, "R3 odd tie");
        send(1'b0, fx(4, 7'h40), M_NEAR, "R3 even tie");
        send(1'b0, fx(0, 7'h40), M_NEAR, "R3 zero tie");
        send(1'b1, fx(7, 7'h40), M_NEAR, "R3 negative odd tie");
        // R4 toward zero
        send(1'b1, fx(7, 7'h7F), M_ZERO, "R4 negative truncate");
        send(1'b0, fx(7, 7'h7F), M_ZERO, "R4 positive truncate");
        // R5 directed
        send(1'b0, fx(3, 7'h01), M_UP,   "R5 up positive");
        send(1'b1, fx(3, 7'h01), M_UP,   "R5 up negative");
        send(1'b1, fx(3, 7'h01), M_DOWN, "R5 down negative");
        send(1'b0, fx(3, 7'h01), M_DOWN, "R5 down positive");
        // R6 sign
        send(1'b1, fx(100, 7'h00), M_NEAR, "R6 exact negative");
        send(1'b1, 64'd0,          M_DOWN, "R6 negative zero");
        // R7 magnitude too large
        send(1'b0, fx(64'h1_0000_0000, 7'h00), M_NEAR, "R7 exact 2^32");
        send(1'b0, fx(64'hFFFF_FFFF, 7'h7F), M_UP, "R7 carry into 2^32");
        send(1'b1, fx(64'h3_0000_0005, 7'h00), M_ZERO, "R7 big negative");
        // R8 signed range edges
        send(1'b0, fx(64'h8000_0000, 7'h00), M_NEAR, "R8 positive 2^31");
        send(1'b0, fx(64'h7FFF_FFFF, 7'h00), M_NEAR, "R8 positive max");
        send(1'b1, fx(64'h8000_0000, 7'h00), M_NEAR, "R8 negative 2^31");
        send(1'b1, fx(64'h8000_0000, 7'h01), M_DOWN, "R8 negative beyond");
        send(1'b0, fx(64'h7FFF_FFFF, 7'h40), M_NEAR, "R8 tie crosses range");
        // R9 / R10
        send(1'b0, 64'd0,        M_UP,   "R9 exact zero");
        send(1'b0, fx(2, 7'h01), M_NEAR, "R9 tiny fraction");
        send(1'b1, fx(2, 7'h7F), M_DOWN, "R10 negative grows");
        // R11
        send(1'b0, fx(64'h8000_0000, 7'h7F), M_ZERO, "R11 invalid with fraction");
        send(1'b1, fx(64'h8000_0001, 7'h3F), M_UP,   "R11 invalid negative fraction");
        idle(1);
        @(negedge clk);
        direct_check(out_valid === 1'b0, "R1",
                     $sformatf("idle gap got out_valid=%b, expected 0", out_valid));

        for (int i = 0; i < 400; i++) begin
            logic [63:0] m;
            m = {$urandom, $urandom};
            m = m >> $urandom_range(0, 40);
            m[63] = 1'b0;
            send(1'($urandom), m, 2'($urandom), "R6 random mixed");
            if (($urandom & 7) == 0) idle(1);
        end
        idle(4);
        direct_check(exp_q.size() == 0, "R1",
                     $sformatf("pending results got %0d, expected 0", exp_q.size()));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule